// File: doc/BRIEF.md
# Cascadable Priority Encoder Chain

This block finds the highest-numbered active request among `8*N_STAGES` active-high request lines and reports its binary index. It is built from identical 8-line stages. Each stage takes a permission input, reports whether it holds any request, and passes permission to the next lower stage only when it is itself enabled and idle. A request in a higher stage therefore blocks every stage below it. The logic is purely combinational.

The top level chains the stages. Stage `N_STAGES-1` is the highest order and takes the global enable. Each disabled stage drives a zero line index, so the low three index bits are the OR of all stage indices. The upper bits are the binary number of the one stage that reports a request. The permission output of the lowest stage leaves the block, so several chains can themselves be cascaded.

Top module: `prio_chain`

## Requirements
- R1: Within a stage, line 7 has the highest priority and line 0 the lowest. The low three bits of `idx_o` give the highest-numbered active line in the winning stage.
- R2: While `en_i` is 0, `idx_o` is 0, `valid_o` is 0 and `en_o` is 0, whatever the requests are.
- R3: While `en_i` is 1 and no request line is 1, `idx_o` is 0, `valid_o` is 0 and `en_o` is 1.
- R4: While `en_i` is 1 and at least one request line is 1, `valid_o` is 1 and `en_o` is 0.
- R5: Request bit `8*s+k` is line `k` of stage `s`. When `valid_o` is 1, `idx_o` equals the bit position of the highest active request bit. With `N_STAGES`=1, the single upper bit of `idx_o` is 0.
- R6: A request in a higher stage blocks all lower stages. At most one stage reports a request at any time, and the upper bits of `idx_o` name that stage even when lower stages also hold requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en_i | input | 1 | Permission into the highest stage |
| req_i | input | 8*N_STAGES | Request lines, bit 8*s+k is line k of stage s |
| idx_o | output | 3+SEL_W | Index of the highest active request, SEL_W = max(1, clog2(N_STAGES)) |
| valid_o | output | 1 | At least one request seen while enabled |
| en_o | output | 1 | Permission out of the lowest stage, for further cascading |

## Verification
The bench builds two copies of the block. One has `N_STAGES`=1, so every combination of the eight lines and the enable can be tried exhaustively. The other has `N_STAGES`=4, which brings the stage-to-stage permission chain and the stage number in the upper index bits within reach. The four-stage copy gets one-hot requests on all 32 lines, sparse and dense random patterns, all-zero and all-one inputs, and requests spread across several stages at once. That last case shows that a higher stage masks the lower ones.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int STAGE_W = 8;
  localparam int IDX_W   = $clog2(STAGE_W);

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/prio_stage.sv
module prio_stage
  import prio_pkg::*;
(
  input  logic               en_i,
  input  logic [STAGE_W-1:0] req_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               grp_o,
  output logic               en_o
);
  logic             any_req;
  logic [IDX_W-1:0] raw_idx;

  assign any_req = |req_i;

  // later (higher) lines overwrite earlier ones
  always_comb begin
    raw_idx = '0;
    for (int i = 0; i < STAGE_W; i++)
      if (req_i[i]) raw_idx = IDX_W'(i);
  end

  assign idx_o = en_i ? raw_idx : '0;
  assign grp_o = en_i & any_req;
  assign en_o  = en_i & ~any_req;

  always_comb begin
    if (!$isunknown({en_i, req_i})) begin
      if (!en_i)
        assert_stage_off_R2: assert (idx_o == '0 && !grp_o && !en_o);
      assert_grp_en_excl_R4: assert (!(grp_o && en_o));
      if (grp_o)
        assert_idx_hits_req_R1: assert (req_i[idx_o]);
      if (grp_o && idx_o != IDX_W'(STAGE_W - 1))
        assert_no_higher_req_R1: assert ((req_i >> (idx_o + 1)) == '0);
    end
  end
endmodule

// File: rtl/prio_merge.sv
module prio_merge
  import prio_pkg::*;
#(
  parameter int N_STAGES = 4,
  localparam int SEL_W   = sel_width(N_STAGES),
  localparam int TOT_W   = IDX_W + SEL_W
) (
  input  logic [N_STAGES-1:0][IDX_W-1:0] st_idx_i,
  input  logic [N_STAGES-1:0]            st_grp_i,
  output logic [TOT_W-1:0]               idx_o,
  output logic                           valid_o
);
  logic [IDX_W-1:0] low_bits;
  logic [SEL_W-1:0] sel_bits;

  // disabled stages drive zero, so plain OR merges
  always_comb begin
    low_bits = '0;
    sel_bits = '0;
    for (int s = 0; s < N_STAGES; s++) begin
      low_bits = low_bits | st_idx_i[s];
      if (st_grp_i[s]) sel_bits = sel_bits | SEL_W'(s);
    end
  end

  assign idx_o   = {sel_bits, low_bits};
  assign valid_o = |st_grp_i;

  always_comb begin
    if (!$isunknown(st_grp_i))
      assert_one_group_R6: assert ($onehot0(st_grp_i));
  end
endmodule

// File: rtl/prio_chain.sv
module prio_chain
  import prio_pkg::*;
#(
  parameter int N_STAGES = 4,
  localparam int SEL_W   = sel_width(N_STAGES),
  localparam int TOT_W   = IDX_W + SEL_W,
  localparam int REQ_W   = STAGE_W * N_STAGES
) (
  input  logic             en_i,
  input  logic [REQ_W-1:0] req_i,
  output logic [TOT_W-1:0] idx_o,
  output logic             valid_o,
  output logic             en_o
);
  logic [N_STAGES:0]             en_chain;
  logic [N_STAGES-1:0][IDX_W-1:0] st_idx;
  logic [N_STAGES-1:0]           st_grp;

  assign en_chain[N_STAGES] = en_i;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    prio_stage u_stage (
      .en_i  (en_chain[s+1]),
      .req_i (req_i[s*STAGE_W +: STAGE_W]),
      .idx_o (st_idx[s]),
      .grp_o (st_grp[s]),
      .en_o  (en_chain[s])
    );
  end

  prio_merge #(.N_STAGES(N_STAGES)) u_merge (
    .st_idx_i (st_idx),
    .st_grp_i (st_grp),
    .idx_o    (idx_o),
    .valid_o  (valid_o)
  );

  assign en_o = en_chain[0];

  always_comb begin
    if (!$isunknown({en_i, req_i})) begin
      if (!en_i)
        assert_chain_off_R2: assert (!valid_o && idx_o == '0 && !en_o);
      if (en_i && req_i == '0)
        assert_chain_idle_R3: assert (!valid_o && idx_o == '0 && en_o);
      if (en_i && req_i != '0)
        assert_chain_busy_R4: assert (valid_o && !en_o);
    end
  end
endmodule

// File: tb/prio_chain_tb.sv
module prio_chain_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  int          total = 0;
  int          bad = 0;
  int          cycles = 0;
  logic        en4, en1;
  logic [31:0] req4;
  logic [7:0]  req1;
  logic [4:0]  idx4;
  logic [3:0]  idx1;
  logic        v4, v1, eo4, eo1;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_chain #(.N_STAGES(4)) u_dut (
    .en_i(en4), .req_i(req4), .idx_o(idx4), .valid_o(v4), .en_o(eo4));
  prio_chain #(.N_STAGES(1)) u_dut_n1 (
    .en_i(en1), .req_i(req1), .idx_o(idx1), .valid_o(v1), .en_o(eo1));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // returns {found, index}
  function automatic logic [5:0] ref_enc(input logic [31:0] r, input int nb);
    logic [5:0] res = '0;
    for (int i = 0; i < nb; i++)
      if (r[i]) res = {1'b1, 5'(i)};
    return res;
  endfunction

  task automatic apply4(input logic en, input logic [31:0] r);
    logic [5:0] e;
    en4 = en; req4 = r;
    #1;
    e = ref_enc(r, 32);
    if (!en) begin
      check("R2 idx", idx4, 0); check("R2 valid", v4, 0); check("R2 en_o", eo4, 0);
    end else if (!e[5]) begin
      check("R3 idx", idx4, 0); check("R3 valid", v4, 0); check("R3 en_o", eo4, 1);
    end else begin
      check("R4 valid", v4, 1); check("R4 en_o", eo4, 0);
      check("R5 idx", idx4, e[4:0]);
      check("R6 stage", idx4[4:3], e[4:3]);
    end
  endtask

  task automatic apply1(input logic en, input logic [7:0] r);
    logic [5:0] e;
    en1 = en; req1 = r;
    #1;
    e = ref_enc({24'd0, r}, 8);
    if (!en) begin
      check("R2 n1 idx", idx1, 0); check("R2 n1 valid", v1, 0); check("R2 n1 en_o", eo1, 0);
    end else if (!e[5]) begin
      check("R3 n1 idx", idx1, 0); check("R3 n1 valid", v1, 0); check("R3 n1 en_o", eo1, 1);
    end else begin
      check("R1 n1 idx", idx1, e[3:0]);
      check("R4 n1 valid", v1, 1); check("R4 n1 en_o", eo1, 0);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    en4 = 1'b0; req4 = '0; en1 = 1'b0; req1 = '0;
    @(negedge clk);
    // R1 R2 R3 R4: exhaustive single stage
    for (int en = 0; en < 2; en++)
      for (int r = 0; r < 256; r++) apply1(en[0], r[7:0]);
    // R2 R3: corners on the wide chain
    apply4(1'b0, 32'hFFFF_FFFF);
    apply4(1'b0, 32'h0000_0001);
    apply4(1'b1, 32'h0);
    apply4(1'b1, 32'hFFFF_FFFF);
    apply4(1'b1, 32'h0000_0001);
    apply4(1'b1, 32'h8000_0000);
    // R6: higher stage masks requests in lower ones
    apply4(1'b1, 32'h0101_0180);
    apply4(1'b1, 32'h00FF_FFFF);
    // R5: one-hot on every line
    for (int i = 0; i < 32; i++) begin
      apply4(1'b1, 32'd1 << i);
      apply4(1'b0, 32'd1 << i);
    end
    // R5 R6: random dense and sparse patterns
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      logic [31:0] c = $urandom;
      apply4(1'b1, a);
      apply4(1'b1, a & b & c);
      apply4(1'b1, (a & b & c) & (32'hFFFF_FFFF >> (n % 32)));
      apply4(n[0], b);
    end
    @(negedge clk);
    finish_run();
  end
endmodule